// File: doc/BRIEF.md
# HDLC Transmit Block Buffer Controller

This block sits between a host and an HDLC bit-level framer and manages the bytes of outgoing frames. The host loads bytes into a 64-entry ring, in blocks whose size is set to 16 or 32 bytes by a select input. After each block the host pulses one of three commands:
- **continue-block** says the block is part of a frame still in progress.
- **end-of-message** says the block closes the frame.
- **flush** discards everything that is buffered.

Committed blocks drain one byte at a time to the framer over a valid/ready handshake. Three sideband markers travel with the bytes. One tells the framer to open a frame with a flag. One tells it to close the frame with checksum and flag. One tells it to abort with a run of seven ones.

The block watches the drain for two failures. If the committed data runs out before an end-of-message block has arrived, it emits an abort and reports an underrun. If the line side reports a collision, the action depends on whether the frame's first block is still in the ring. If it is, the frame restarts from its first byte with no host action. If it is not, everything is flushed and the host is told to rewrite the whole frame.

Status bits are sticky and are cleared by a status read. An interrupt output combines them under individual masks, except the repeat request, which cannot be masked.

Top module: `hdlc_txfifo_ctrl`

## Requirements
- R1: After reset, `fr_valid` is 0 and `stat_data` is 4'b0001. The bits of `stat_data` are: bit 0 pool-ready, bit 1 underrun, bit 2 repeat request, bit 3 overflow. With both mask bits 0, `irq` is 1.
- R2: Bytes reach the framer in the order the host wrote them. A byte is transferred on a cycle where `fr_valid` and `fr_ready` are both 1. While `fr_valid` is 1 and `fr_ready` is 0, `fr_data` holds its value.
- R3: The first byte of each frame carries `fr_sof`=1 and no other byte does. A continue-block command lets the frame go on into the next block without `fr_eof`.
- R4: In an end-of-message block, the final byte carries `fr_eof`=1, and the frame is then complete.
- R5: The pool-ready status bit is set when the final byte of any block is transferred, and by a flush command.
- R6: With `blk_sel`=0 the block size is 16; with `blk_sel`=1 it is 32. The overflow bit is set when a byte is written while the uncommitted count already equals the block size. Exactly one block-size of bytes does not set it.
- R7: If a frame has no committed bytes left and no end-of-message block has arrived, the block raises the underrun bit. It then offers one beat with `fr_abort`=1, `fr_sof`=0 and `fr_eof`=0.
- R8: A collision while the frame's first block is still in the ring restarts the frame from its first byte, which again carries `fr_sof`. The repeat bit is not set.
- R9: A collision after the first block has been fully transferred sets the repeat bit. It drops `fr_valid` and discards all buffered data, so the next bytes written form a fresh frame.
- R10: `irq` is 1 whenever the repeat bit is set, whatever `irq_mask` holds. `irq_mask[0]` masks pool-ready and `irq_mask[1]` masks underrun; overflow never drives `irq`.
- R11: A `stat_rd` pulse clears every status bit at the next edge. An event raised in that same cycle stays set.
- R12: A flush command drops committed but unsent data. After it `fr_valid` stays 0 until new blocks are committed.
- R13: A collision in the very cycle that the first block's final byte is transferred counts as inside the first block. The frame restarts, and no pool-ready is raised for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host byte write strobe |
| host_wr_data | input | 8 | Host byte |
| blk_sel | input | 1 | Block size select: 0 = 16, 1 = 32 |
| cmd_block | input | 1 | Continue-block command pulse |
| cmd_end | input | 1 | End-of-message command pulse |
| cmd_reset | input | 1 | Flush command pulse |
| stat_rd | input | 1 | Status read; clears the sticky bits |
| irq_mask | input | 2 | Mask for pool-ready (bit 0) and underrun (bit 1) |
| stat_data | output | 4 | Sticky status bits |
| irq | output | 1 | Interrupt request |
| line_coll | input | 1 | Collision report from the line side |
| fr_valid | output | 1 | Byte or abort beat offered to the framer |
| fr_ready | input | 1 | Framer accepts the beat |
| fr_data | output | 8 | Byte to the framer |
| fr_sof | output | 1 | Open a frame before this byte |
| fr_eof | output | 1 | Close the frame after this byte |
| fr_abort | output | 1 | Abort beat |

## Verification
Two events can fall in the same cycle: a collision from the line side, and the transfer of the byte that completes the frame's first block. The bench holds `fr_ready` high and counts the beats accepted. On the cycle that offers the sixteenth byte, it pulses `line_coll`. Two things are then judged. The status read straight after that edge must show no pool-ready. The next beats must repeat the whole frame from its first byte, with the start marker on that byte.

// File: rtl/hdlc_txf_pkg.sv
package hdlc_txf_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SEND  = 2'd1,
    TX_ABORT = 2'd2
  } tx_state_e;

  // status bit positions
  localparam int ST_POOL = 0;
  localparam int ST_UNDR = 1;
  localparam int ST_REPT = 2;
  localparam int ST_OVFL = 3;
  localparam int ST_W    = 4;

  // selected block size in bytes
  function automatic int unsigned blk_bytes(input logic sel,
                                            input int unsigned small_b,
                                            input int unsigned large_b);
    return sel ? large_b : small_b;
  endfunction

  // true when the uncommitted count has already reached the block size
  function automatic logic blk_full(input int unsigned count,
                                    input int unsigned size);
    return count >= size;
  endfunction

endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/txf_blkq.sv
module txf_blkq #(
  parameter int ENT = 4,
  parameter int AW  = 6,
  localparam int IW = (ENT > 1) ? $clog2(ENT) : 1,
  localparam int NW = $clog2(ENT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [AW-1:0] push_end,
  input  logic          push_last,
  input  logic          pop,
  output logic          empty,
  output logic [AW-1:0] head_end,
  output logic          head_last
);

  logic [ENT*AW-1:0] ends_flat;
  logic [ENT-1:0]    lasts;
  logic [IW-1:0]     hd_q, tl_q;
  logic [NW-1:0]     n_q;

  function automatic logic [IW-1:0] idx_next(input logic [IW-1:0] i);
    return (int'(i) == ENT - 1) ? '0 : i + IW'(1);
  endfunction

  for (genvar g = 0; g < ENT; g++) begin : g_slot
    logic [AW-1:0] e_q;
    logic          l_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_q <= '0;
        l_q <= 1'b0;
      end else if (push && !flush && tl_q == IW'(g)) begin
        e_q <= push_end;
        l_q <= push_last;
      end
    end
    assign ends_flat[g*AW +: AW] = e_q;
    assign lasts[g]              = l_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q <= '0;
      tl_q <= '0;
      n_q  <= '0;
    end else if (flush) begin
      hd_q <= '0;
      tl_q <= '0;
      n_q  <= '0;
    end else begin
      if (push) tl_q <= idx_next(tl_q);
      if (pop)  hd_q <= idx_next(hd_q);
      case ({push, pop})
        2'b10:   n_q <= n_q + NW'(1);
        2'b01:   n_q <= n_q - NW'(1);
        default: n_q <= n_q;
      endcase
    end
  end

  assign empty     = (n_q == '0);
  assign head_end  = ends_flat[hd_q*AW +: AW];
  assign head_last = lasts[hd_q];

  // the read side only retires a block that exists
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !flush |-> n_q != '0);

endmodule

// File: rtl/txf_stat.sv
module txf_stat
  import hdlc_txf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] evt,
  input  logic            clr,
  input  logic [1:0]      mask,
  output logic [ST_W-1:0] stat,
  output logic            irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= ST_W'(1) << ST_POOL;
    else        stat <= (clr ? '0 : stat) | evt;
  end

  assign irq = (stat[ST_POOL] & ~mask[0]) |
               (stat[ST_UNDR] & ~mask[1]) |
               stat[ST_REPT];

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !evt[ST_UNDR] |=> !stat[ST_UNDR]);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt[ST_REPT] |=> stat[ST_REPT]);

endmodule

// File: rtl/hdlc_txfifo_ctrl.sv
module hdlc_txfifo_ctrl
  import hdlc_txf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BLK_S = 16,
  parameter int BLK_L = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr_en,
  input  logic [7:0] host_wr_data,
  input  logic       blk_sel,
  input  logic       cmd_block,
  input  logic       cmd_end,
  input  logic       cmd_reset,
  input  logic       stat_rd,
  input  logic [1:0] irq_mask,
  output logic [3:0] stat_data,
  output logic       irq,
  input  logic       line_coll,
  output logic       fr_valid,
  input  logic       fr_ready,
  output logic [7:0] fr_data,
  output logic       fr_sof,
  output logic       fr_eof,
  output logic       fr_abort
);

  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1) + 1;
  localparam int QENT = DEPTH / BLK_S;

  tx_state_e     st_q;
  logic [AW-1:0] wp_q, rp_q, fst_q;
  logic [CW-1:0] wcnt_q;
  logic          sof_q, first_q;

  logic          q_empty, q_last;
  logic [AW-1:0] q_end;
  logic [7:0]    rd_byte;

  // named internal events
  logic          host_wr, ovf_evt, cmd_any, q_push;
  logic [AW-1:0] wp_nx, rp_inc;
  logic [CW-1:0] wcnt_nx;
  logic          sending, at_blk_end, hs;
  logic          coll_act, rewind_evt, rep_evt;
  logic          byte_hs, blk_done, frame_done, udr_evt, q_flush, xpr_evt;
  logic [ST_W-1:0] evts;

  // host side
  assign host_wr = host_wr_en && !cmd_reset;
  assign ovf_evt = host_wr && blk_full(int'(wcnt_q), blk_bytes(blk_sel, BLK_S, BLK_L));
  assign wp_nx   = host_wr ? wp_q + AW'(1) : wp_q;
  assign wcnt_nx = host_wr ? wcnt_q + CW'(1) : wcnt_q;
  assign cmd_any = (cmd_block || cmd_end) && !cmd_reset && !rep_evt;
  assign q_push  = cmd_any && (wcnt_nx != '0);

  // framer side
  assign rp_inc     = rp_q + AW'(1);
  assign sending    = (st_q == TX_SEND) && !q_empty;
  assign at_blk_end = (rp_inc == q_end);
  assign fr_valid   = sending || (st_q == TX_ABORT);
  assign fr_data    = rd_byte;
  assign fr_sof     = sending && sof_q;
  assign fr_eof     = sending && at_blk_end && q_last;
  assign fr_abort   = (st_q == TX_ABORT);
  assign hs         = fr_valid && fr_ready;

  // collision, underrun and block retirement
  assign coll_act   = line_coll && (st_q == TX_SEND) && !cmd_reset;
  assign rewind_evt = coll_act && first_q;
  assign rep_evt    = coll_act && !first_q;
  assign byte_hs    = hs && sending && !coll_act && !cmd_reset;
  assign blk_done   = byte_hs && at_blk_end;
  assign frame_done = blk_done && q_last;
  assign udr_evt    = (st_q == TX_SEND) && q_empty && !coll_act && !cmd_reset;
  assign q_flush    = cmd_reset || rep_evt;
  assign xpr_evt    = blk_done || cmd_reset;

  always_comb begin
    evts          = '0;
    evts[ST_POOL] = xpr_evt;
    evts[ST_UNDR] = udr_evt;
    evts[ST_REPT] = rep_evt;
    evts[ST_OVFL] = ovf_evt;
  end

  txf_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk   (clk),
    .we    (host_wr),
    .waddr (wp_q),
    .wdata (host_wr_data),
    .raddr (rp_q),
    .rdata (rd_byte)
  );

  txf_blkq #(.ENT(QENT), .AW(AW)) u_blkq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (q_flush),
    .push      (q_push),
    .push_end  (wp_nx),
    .push_last (cmd_end),
    .pop       (blk_done),
    .empty     (q_empty),
    .head_end  (q_end),
    .head_last (q_last)
  );

  txf_stat u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evts),
    .clr   (stat_rd),
    .mask  (irq_mask),
    .stat  (stat_data),
    .irq   (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TX_IDLE;
      wp_q    <= '0;
      rp_q    <= '0;
      fst_q   <= '0;
      wcnt_q  <= '0;
      sof_q   <= 1'b0;
      first_q <= 1'b0;
    end else if (q_flush) begin
      st_q    <= TX_IDLE;
      wp_q    <= '0;
      rp_q    <= '0;
      fst_q   <= '0;
      wcnt_q  <= '0;
      sof_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      wp_q   <= wp_nx;
      wcnt_q <= cmd_any ? '0 : wcnt_nx;
      case (st_q)
        TX_IDLE: begin
          if (!q_empty) begin
            st_q    <= TX_SEND;
            sof_q   <= 1'b1;
            first_q <= 1'b1;
            fst_q   <= rp_q;
          end
        end
        TX_SEND: begin
          if (rewind_evt) begin
            rp_q  <= fst_q;
            sof_q <= 1'b1;
          end else if (udr_evt) begin
            st_q <= TX_ABORT;
          end else if (byte_hs) begin
            rp_q  <= rp_inc;
            sof_q <= 1'b0;
            if (blk_done)   first_q <= 1'b0;
            if (frame_done) st_q    <= TX_IDLE;
          end
        end
        TX_ABORT: begin
          if (hs) st_q <= TX_IDLE;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && !fr_ready && !line_coll && !cmd_reset && !host_wr_en
    |=> fr_valid && $stable(fr_data));

  p_abort_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fr_abort |-> fr_valid && !fr_sof && !fr_eof);

  p_udr_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    udr_evt |=> fr_valid && fr_abort);

  p_rewind_sof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_evt && !cmd_reset |=> fr_valid && fr_sof);

  p_rep_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rep_evt |=> !fr_valid && q_empty);

  p_rep_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rep_evt |=> irq);

  p_flush_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> !fr_valid && stat_data[ST_POOL]);

  p_rewind_keeps_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_evt && !cmd_reset |=> !q_empty && !stat_data[ST_REPT]);

endmodule

// File: tb/hdlc_txfifo_ctrl_test.sv
module hdlc_txfifo_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr_en = 1'b0;
  logic [7:0] host_wr_data = '0;
  logic blk_sel = 1'b0;
  logic cmd_block = 1'b0, cmd_end = 1'b0, cmd_reset = 1'b0;
  logic stat_rd = 1'b0;
  logic [1:0] irq_mask = '0;
  logic [3:0] stat_data;
  logic irq;
  logic line_coll = 1'b0;
  logic fr_valid, fr_sof, fr_eof, fr_abort;
  logic [7:0] fr_data;
  logic fr_ready;
  logic rdy_lvl = 1'b0, bp_mode = 1'b0, bp_tgl = 1'b0;

  int vectors = 0;
  int fails = 0;
  int log_n = 0;
  logic [7:0] lg_d [512];
  bit lg_s [512];
  bit lg_e [512];
  bit lg_a [512];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) bp_tgl <= ~bp_tgl;
  assign fr_ready = bp_mode ? bp_tgl : rdy_lvl;

  hdlc_txfifo_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .blk_sel(blk_sel), .cmd_block(cmd_block), .cmd_end(cmd_end), .cmd_reset(cmd_reset),
    .stat_rd(stat_rd), .irq_mask(irq_mask), .stat_data(stat_data), .irq(irq),
    .line_coll(line_coll), .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_data(fr_data),
    .fr_sof(fr_sof), .fr_eof(fr_eof), .fr_abort(fr_abort)
  );

  // beat log: a beat seen at the falling edge completes at the next rising edge
  always @(negedge clk) begin
    if (rst_n && fr_valid && fr_ready) begin
      lg_d[log_n % 512] = fr_data;
      lg_s[log_n % 512] = fr_sof;
      lg_e[log_n % 512] = fr_eof;
      lg_a[log_n % 512] = fr_abort;
      log_n++;
    end
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      host_wr_en = 1'b1;
      host_wr_data = 8'(base + i);
      tick();
    end
    host_wr_en = 1'b0;
  endtask

  task automatic pulse_block();  cmd_block = 1'b1; tick(); cmd_block = 1'b0; endtask
  task automatic pulse_end();    cmd_end   = 1'b1; tick(); cmd_end   = 1'b0; endtask
  task automatic pulse_flush();  cmd_reset = 1'b1; tick(); cmd_reset = 1'b0; endtask
  task automatic pulse_read();   stat_rd   = 1'b1; tick(); stat_rd   = 1'b0; endtask

  task automatic wait_beats(input int target, input string req);
    int guard = 0;
    while (log_n < target && guard < 400) begin
      tick();
      guard++;
    end
    chk_eq({req, " beats arrived"}, log_n >= target, 1);
  endtask

  // count mismatches in a logged frame: data run, sof first only, eof last only
  task automatic chk_frame(input string req, input int start, input int n, input int dbase);
    int errs = 0;
    for (int i = 0; i < n; i++) begin
      int k = (start + i) % 512;
      if (lg_d[k] != 8'(dbase + i)) errs++;
      if (lg_s[k] != (i == 0))      errs++;
      if (lg_e[k] != (i == n - 1))  errs++;
      if (lg_a[k])                  errs++;
    end
    chk_eq(req, errs, 0);
  endtask

  task automatic clean();
    rdy_lvl = 1'b0;
    bp_mode = 1'b0;
    irq_mask = '0;
    pulse_flush();
    pulse_read();
    tick();
  endtask

  task automatic t_reset_state();
    chk_eq("R1 fr_valid", fr_valid, 0);
    chk_eq("R1 stat", stat_data, 4'b0001);
    chk_eq("R1 irq", irq, 1);
  endtask

  task automatic t_read_clear();
    pulse_read();
    chk_eq("R11 stat cleared", stat_data, 0);
    chk_eq("R11 irq low", irq, 0);
  endtask

  task automatic t_single_frame();
    int b;
    clean();
    blk_sel = 1'b0;
    rdy_lvl = 1'b1;
    b = log_n;
    wr_bytes(10, 8'h10);
    pulse_end();
    wait_beats(b + 10, "R4");
    tick(2);
    chk_frame("R2/R4 single frame", b, 10, 8'h10);
    chk_eq("R5 pool ready after block", stat_data[0], 1);
    chk_eq("R4 idle after frame", fr_valid, 0);
  endtask

  task automatic t_two_blocks();
    int b;
    clean();
    blk_sel = 1'b0;
    b = log_n;
    wr_bytes(16, 8'h20);
    pulse_block();
    wr_bytes(5, 8'h30);
    pulse_end();
    bp_mode = 1'b1;
    wait_beats(b + 21, "R3");
    tick(2);
    bp_mode = 1'b0;
    chk_frame("R3/R2 two blocks with backpressure", b, 21, 8'h20);
    chk_eq("R3 no underrun", stat_data[1], 0);
  endtask

  task automatic t_overflow();
    clean();
    blk_sel = 1'b0;
    wr_bytes(16, 0);
    chk_eq("R6 16 bytes no overflow", stat_data[3], 0);
    wr_bytes(1, 0);
    chk_eq("R6 17th byte overflow", stat_data[3], 1);
    clean();
    blk_sel = 1'b1;
    wr_bytes(32, 0);
    chk_eq("R6 32 bytes at size 32 no overflow", stat_data[3], 0);
    wr_bytes(1, 0);
    chk_eq("R6 33rd byte overflow", stat_data[3], 1);
    blk_sel = 1'b0;
  endtask

  task automatic t_underrun();
    int b;
    clean();
    rdy_lvl = 1'b1;
    b = log_n;
    wr_bytes(16, 8'h40);
    pulse_block();
    wait_beats(b + 17, "R7");
    tick(2);
    chk_eq("R7 abort beat", lg_a[(b + 16) % 512], 1);
    chk_eq("R7 abort no sof/eof", lg_s[(b + 16) % 512] | lg_e[(b + 16) % 512], 0);
    chk_eq("R7 underrun bit", stat_data[1], 1);
    irq_mask = 2'b10;
    #1;
    chk_eq("R10 pool-ready unmasked irq", irq, 1);
    irq_mask = 2'b11;
    #1;
    chk_eq("R10 both masked irq", irq, 0);
  endtask

  // collision while beat k is offered, fr_ready held high
  task automatic t_collide(input int k, input string req, input bit expect_rep);
    int b;
    clean();
    blk_sel = 1'b0;
    b = log_n;
    if (expect_rep) begin
      wr_bytes(16, 8'h60);
      pulse_block();
      wr_bytes(16, 8'h70);
      pulse_block();
    end else begin
      wr_bytes(16, 8'h60);
      pulse_block();
      wr_bytes(4, 8'h70);
      pulse_end();
    end
    pulse_read();
    rdy_lvl = 1'b1;
    do tick(); while (log_n - b < k);
    line_coll = 1'b1;
    tick();
    line_coll = 1'b0;
    if (expect_rep) begin
      chk_eq({req, " repeat bit"}, stat_data[2], 1);
      chk_eq({req, " valid dropped"}, fr_valid, 0);
      irq_mask = 2'b11;
      #1;
      chk_eq("R10 repeat ignores mask", irq, 1);
      irq_mask = 2'b00;
      pulse_read();
      b = log_n;
      wr_bytes(3, 8'hA0);
      pulse_end();
      wait_beats(b + 3, req);
      chk_frame({req, " fresh frame after flush"}, b, 3, 8'hA0);
    end else begin
      chk_eq({req, " no pool-ready from cut byte"}, stat_data[0], 0);
      b = log_n;
      wait_beats(b + 20, req);
      tick(2);
      chk_frame({req, " frame restarted"}, b, 20, 8'h60);
      chk_eq({req, " no repeat"}, stat_data[2], 0);
    end
  endtask

  task automatic t_flush_cmd();
    int b;
    clean();
    wr_bytes(8, 8'hC0);
    pulse_end();
    tick(3);
    pulse_read();
    pulse_flush();
    chk_eq("R12 valid after flush", fr_valid, 0);
    chk_eq("R12 pool ready after flush", stat_data[0], 1);
    b = log_n;
    rdy_lvl = 1'b1;
    tick(10);
    chk_eq("R12 nothing sent", log_n - b, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset_state();
    t_read_clear();
    t_single_frame();
    t_two_blocks();
    t_overflow();
    t_underrun();
    t_collide(5, "R8", 1'b0);
    t_collide(15, "R13", 1'b0);
    t_collide(17, "R9", 1'b1);
    t_flush_cmd();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule